// File: doc/BRIEF.md
# Single-Wire Configuration Command Sequencer

This block sits behind a single-wire pulse decoder and turns its stream of decoded bits into configuration actions. From the normal (idle) state it watches for one of two six-bit entry codes: one opens a register-programming session, the other hands the line to a read-back serializer for a fixed number of bit clocks. Inside a programming session, ten-bit frames either overwrite one of three eight-bit working words, which drive the analogue trim and divider settings at once, or jump to another state.

Two of the jump targets copy the working words into a non-volatile shadow copy. One of them also sets a sticky lock, after which the shadow copy can no longer be changed. The shadow copy is cleared to its defaults only by its own power-on reset `por_n`. The functional reset `rst_n` leaves it alone, and after `rst_n` the working words are reloaded from it during a single load cycle. `rst_n` must be released synchronously to `clk` by the reset logic upstream.

Top module: `swire_cfg_fsm`

## Requirements
- R1: While reset is active and for the first cycle after `rst_n` is released, `cfg_state` is 5 (load) and `out_en` is 0. One clock later `cfg_state` is 0 (idle) and the working words equal the shadow copy. After `por_n` the shadow copy is word0 = 0x02, word1 = 0x02 and word2 = 0x0C, with both flags at 0.
- R2: In idle, bits are gathered in groups of six, and the first bit received lands in vector bit 0. The vector 6'b001100 moves to programming (`cfg_state` 1). The vector 6'b110111 moves to read-back (`cfg_state` 4). Any other group leaves the state at idle and starts a fresh group.
- R3: A `timeout` pulse discards any partly received group or frame. In read-back it returns the state to idle.
- R4: In programming, frames are ten bits long, and frame bit i is the i-th bit received. Bits 0 and 1 select the target: (0,0) selects word0, (1,0) selects word1 and (0,1) selects word2. Payload bit k is frame bit k+2. The addressed word takes the payload on the clock that accepts the tenth bit.
- R5: In programming, a frame with bits 0 and 1 both set is a jump on its payload. 0xFF goes to idle, 0x0F goes to commit-without-lock (`cfg_state` 2), 0xAA goes to commit-with-lock (`cfg_state` 3), and any other payload goes to idle. A jump writes no word.
- R6: On entering state 2 or 3 while unlocked, the shadow copy takes the working words and the written flag is set. `prog_strobe` is high for exactly the one following cycle. Entering state 3 also sets `nv_locked` and pulses `lock_strobe` in the same cycle.
- R7: Once `nv_locked` is 1, entering state 2 or 3 leaves the shadow copy unchanged and pulses neither strobe. The lock stays set until `por_n`.
- R8: In states 2 and 3, a jump frame with payload 0x00 returns to idle. Every other frame is ignored and changes neither the state nor any word.
- R9: In read-back, the state returns to idle on the clock of the `RB_BITS`-th (default 30) bit pulse.
- R10: In idle, `out_en` follows `en_pin`. In states 1 to 4, `out_en` is 1 whatever `en_pin` does.
- R11: A `rst_n` pulse without `por_n` restores the working words to the last committed shadow values, discarding uncommitted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low functional reset |
| por_n | input | 1 | Asynchronous active-low reset of the shadow copy and flags |
| bit_vld | input | 1 | One-cycle strobe: a decoded bit is present |
| bit_val | input | 1 | Value of the decoded bit |
| timeout | input | 1 | Decoder inter-bit timeout pulse |
| en_pin | input | 1 | Enable pin level |
| word0 | output | 8 | Working word 0 |
| word1 | output | 8 | Working word 1 |
| word2 | output | 8 | Working word 2 |
| cfg_state | output | 3 | 0 idle, 1 programming, 2 commit, 3 commit with lock, 4 read-back, 5 load |
| prog_strobe | output | 1 | One-cycle pulse per accepted commit |
| lock_strobe | output | 1 | One-cycle pulse when the lock is set |
| out_en | output | 1 | Output enable towards the clock driver |
| nv_locked | output | 1 | Shadow copy lock flag |
| nv_written | output | 1 | Shadow copy has been committed at least once |

## Verification
Every result of a bit pulse is registered once. The words, the state, both flags and the strobes all change on the clock edge that samples the last bit of a group or frame. The bench drives each bit for one cycle from a falling edge and samples at the very next falling edge, which is also where it checks that a strobe is high. `out_en` is combinational on state and pin, so it is checked at the falling edge right after the pin changes. After a `rst_n` release, the load state is checked at once and the reloaded words one falling edge later.

// File: rtl/swire_cfg_pkg.sv
package swire_cfg_pkg;

  localparam int WORD_W     = 8;
  localparam int NWORDS     = 3;
  localparam int ENTRY_BITS = 6;
  localparam int FRAME_BITS = WORD_W + 2;

  typedef logic [NWORDS-1:0][WORD_W-1:0] word_arr_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PROG     = 3'd1,
    ST_NV_PLAIN = 3'd2,
    ST_NV_LOCK  = 3'd3,
    ST_RDBK     = 3'd4,
    ST_LOAD     = 3'd5
  } cfg_state_e;

  // entry codes, first received bit at index 0
  localparam logic [ENTRY_BITS-1:0] CODE_PROG = 6'b001100;
  localparam logic [ENTRY_BITS-1:0] CODE_RDBK = 6'b110111;

  // jump payloads, payload bit 0 received first
  localparam logic [WORD_W-1:0] JMP_EXIT    = 8'hFF;
  localparam logic [WORD_W-1:0] JMP_NV      = 8'h0F;
  localparam logic [WORD_W-1:0] JMP_NV_LOCK = 8'hAA;
  localparam logic [WORD_W-1:0] JMP_NV_EXIT = 8'h00;

endpackage

// File: rtl/swire_frame_acc.sv
module swire_frame_acc
  import swire_cfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_vld,
  input  logic                  bit_val,
  input  logic                  flush,
  input  logic                  long_frame,
  output logic                  done,
  output logic [FRAME_BITS-1:0] frame
);

  localparam int CW = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST_LONG  = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(ENTRY_BITS - 1);

  logic [CW-1:0]         cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] frm_q, frm_d;
  logic [CW-1:0]         last_idx;

  assign last_idx = long_frame ? LAST_LONG : LAST_SHORT;
  assign done     = bit_vld && !flush && (cnt_q == last_idx);

  always_comb begin
    frame = frm_q;
    frame[cnt_q] = bit_val;
  end

  always_comb begin
    cnt_d = cnt_q;
    frm_d = frm_q;
    if (flush) begin
      cnt_d = '0;
    end else if (bit_vld) begin
      frm_d = frame;
      cnt_d = done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      frm_q <= '0;
    end else if (flush || bit_vld) begin
      cnt_q <= cnt_d;
      frm_q <= frm_d;
    end
  end

endmodule

// File: rtl/swire_nv_shadow.sv
module swire_nv_shadow
  import swire_cfg_pkg::*;
#(
  parameter word_arr_t DEFS = '0
) (
  input  logic      clk,
  input  logic      por_n,
  input  logic      commit,
  input  logic      lock_req,
  input  word_arr_t wr_words,
  output word_arr_t nv_words,
  output logic      locked,
  output logic      written,
  output logic      prog_pulse,
  output logic      lock_pulse
);

  word_arr_t words_q, words_d;
  logic      lock_q, lock_d, wr_q, wr_d, prog_q, lk_p_q;
  logic      accept;

  assign accept = commit && !lock_q;

  always_comb begin
    words_d = words_q;
    lock_d  = lock_q;
    wr_d    = wr_q;
    if (accept) begin
      words_d = wr_words;
      wr_d    = 1'b1;
      lock_d  = lock_q | lock_req;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      words_q <= DEFS;
      lock_q  <= 1'b0;
      wr_q    <= 1'b0;
      prog_q  <= 1'b0;
      lk_p_q  <= 1'b0;
    end else begin
      if (accept) begin
        words_q <= words_d;
        lock_q  <= lock_d;
        wr_q    <= wr_d;
      end
      prog_q <= accept;
      lk_p_q <= accept && lock_req;
    end
  end

  assign nv_words   = words_q;
  assign locked     = lock_q;
  assign written    = wr_q;
  assign prog_pulse = prog_q;
  assign lock_pulse = lk_p_q;

endmodule

// File: rtl/swire_word_bank.sv
module swire_word_bank
  import swire_cfg_pkg::*;
#(
  parameter word_arr_t DEFS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_all,
  input  word_arr_t         load_words,
  input  logic [NWORDS-1:0] wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output word_arr_t         words
);

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic [WORD_W-1:0] w_q, w_d;
    logic              w_ce;

    assign w_ce = load_all || wr_en[i];

    always_comb begin
      w_d = wr_data;
      if (load_all) w_d = load_words[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     w_q <= DEFS[i];
      else if (w_ce)  w_q <= w_d;
    end

    assign words[i] = w_q;
  end

endmodule

// File: rtl/swire_cfg_fsm.sv
module swire_cfg_fsm
  import swire_cfg_pkg::*;
#(
  parameter int               RB_BITS = 30,
  parameter logic [WORD_W-1:0] DEF_W0 = 8'h02,
  parameter logic [WORD_W-1:0] DEF_W1 = 8'h02,
  parameter logic [WORD_W-1:0] DEF_W2 = 8'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              timeout,
  input  logic              en_pin,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1,
  output logic [WORD_W-1:0] word2,
  output logic [2:0]        cfg_state,
  output logic              prog_strobe,
  output logic              lock_strobe,
  output logic              out_en,
  output logic              nv_locked,
  output logic              nv_written
);

  localparam word_arr_t DEFS = {DEF_W2, DEF_W1, DEF_W0};
  localparam int RBW = $clog2(RB_BITS + 1);
  localparam logic [RBW-1:0] RB_LAST = RBW'(RB_BITS - 1);

  cfg_state_e state_q, state_d;
  logic [RBW-1:0] rb_cnt_q, rb_cnt_d;

  logic                  acc_vld, acc_done;
  logic [FRAME_BITS-1:0] frame;
  logic [1:0]            sel;
  logic [WORD_W-1:0]     payload;
  logic                  is_jump;
  logic [NWORDS-1:0]     wr_en;
  logic                  commit, lock_req;
  word_arr_t             work_words, nv_words;

  assign acc_vld = bit_vld && (state_q != ST_RDBK) && (state_q != ST_LOAD);
  assign sel     = frame[1:0];
  assign payload = frame[FRAME_BITS-1:2];
  assign is_jump = (sel == 2'b11);

  swire_frame_acc u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (acc_vld),
    .bit_val   (bit_val),
    .flush     (timeout),
    .long_frame(state_q != ST_IDLE),
    .done      (acc_done),
    .frame     (frame)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    rb_cnt_d = '0;
    wr_en    = '0;
    unique case (state_q)
      ST_LOAD: state_d = ST_IDLE;
      ST_IDLE: begin
        if (acc_done) begin
          if (frame[ENTRY_BITS-1:0] == CODE_PROG)      state_d = ST_PROG;
          else if (frame[ENTRY_BITS-1:0] == CODE_RDBK) state_d = ST_RDBK;
        end
      end
      ST_PROG: begin
        if (acc_done) begin
          if (is_jump) begin
            unique case (payload)
              JMP_NV:      state_d = ST_NV_PLAIN;
              JMP_NV_LOCK: state_d = ST_NV_LOCK;
              default:     state_d = ST_IDLE;
            endcase
          end else begin
            unique case (sel)
              2'b00:   wr_en = 3'b001;
              2'b01:   wr_en = 3'b010;
              default: wr_en = 3'b100;
            endcase
          end
        end
      end
      ST_NV_PLAIN, ST_NV_LOCK: begin
        if (acc_done && is_jump && (payload == JMP_NV_EXIT)) state_d = ST_IDLE;
      end
      ST_RDBK: begin
        rb_cnt_d = rb_cnt_q;
        if (timeout) begin
          state_d = ST_IDLE;
        end else if (bit_vld) begin
          if (rb_cnt_q == RB_LAST) state_d = ST_IDLE;
          else                     rb_cnt_d = rb_cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_LOAD;
      rb_cnt_q <= '0;
    end else begin
      state_q  <= state_d;
      rb_cnt_q <= rb_cnt_d;
    end
  end

  assign commit   = (state_q == ST_PROG) &&
                    ((state_d == ST_NV_PLAIN) || (state_d == ST_NV_LOCK));
  assign lock_req = (state_d == ST_NV_LOCK);

  swire_word_bank #(.DEFS(DEFS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_all  (state_q == ST_LOAD),
    .load_words(nv_words),
    .wr_en     (wr_en),
    .wr_data   (payload),
    .words     (work_words)
  );

  swire_nv_shadow #(.DEFS(DEFS)) u_nv (
    .clk       (clk),
    .por_n     (por_n),
    .commit    (commit),
    .lock_req  (lock_req),
    .wr_words  (work_words),
    .nv_words  (nv_words),
    .locked    (nv_locked),
    .written   (nv_written),
    .prog_pulse(prog_strobe),
    .lock_pulse(lock_strobe)
  );

  always_comb begin
    unique case (state_q)
      ST_IDLE: out_en = en_pin;
      ST_LOAD: out_en = 1'b0;
      default: out_en = 1'b1;
    endcase
  end

  assign word0     = work_words[0];
  assign word1     = work_words[1];
  assign word2     = work_words[2];
  assign cfg_state = state_q;

endmodule

// File: rtl/swire_cfg_chk.sv
module swire_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_n,
  input logic [2:0] cfg_state,
  input logic       prog_strobe,
  input logic       lock_strobe,
  input logic       nv_locked,
  input logic [7:0] word0,
  input logic [7:0] word1,
  input logic [7:0] word2
);

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cfg_state == 3'd5) |=> (cfg_state == 3'd0)); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prog_strobe |=> !prog_strobe); // R6

  AST_STROBE_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prog_strobe |-> (cfg_state == 3'd2 || cfg_state == 3'd3)); // R6

  AST_LOCK_NEEDS_PROG: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    lock_strobe |-> prog_strobe); // R6

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    nv_locked |=> nv_locked); // R7

  AST_NO_COMMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    prog_strobe |-> !$past(nv_locked)); // R7

  AST_WORDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (cfg_state != 3'd1 && cfg_state != 3'd5) |=> $stable({word0, word1, word2})); // R8

endmodule

bind swire_cfg_fsm swire_cfg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_n      (por_n),
  .cfg_state  (cfg_state),
  .prog_strobe(prog_strobe),
  .lock_strobe(lock_strobe),
  .nv_locked  (nv_locked),
  .word0      (word0),
  .word1      (word1),
  .word2      (word2)
);

// File: tb/tb_swire_cfg_fsm.sv
module tb_swire_cfg_fsm;

  logic clk = 1'b0;
  logic rst_n, por_n, bit_vld, bit_val, timeout, en_pin;
  logic [7:0] word0, word1, word2;
  logic [2:0] cfg_state;
  logic prog_strobe, lock_strobe, out_en, nv_locked, nv_written;

  always #2 clk = ~clk;  // 250 MHz

  swire_cfg_fsm dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .timeout(timeout), .en_pin(en_pin), .word0(word0), .word1(word1), .word2(word2),
    .cfg_state(cfg_state), .prog_strobe(prog_strobe), .lock_strobe(lock_strobe),
    .out_en(out_en), .nv_locked(nv_locked), .nv_written(nv_written)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // bench model
  logic [7:0] m_w [3];
  logic [7:0] m_sh [3];
  logic m_lk, m_wr;
  int   m_st;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_words(input string tag);
    chk(word0 == m_w[0], tag, word0, m_w[0]);
    chk(word1 == m_w[1], tag, word1, m_w[1]);
    chk(word2 == m_w[2], tag, word2, m_w[2]);
  endtask

  task automatic send_bit(input logic v);
    int gap = $urandom_range(0, 2);
    repeat (gap) @(negedge clk);
    bit_vld = 1'b1;
    bit_val = v;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_bits(input logic [9:0] b, input int n);
    for (int i = 0; i < n; i++) send_bit(b[i]);
  endtask

  task automatic pulse_timeout();
    timeout = 1'b1;
    @(negedge clk);
    timeout = 1'b0;
  endtask

  function automatic int word_index(input logic c0, input logic c1);
    return c1 ? 2 : (c0 ? 1 : 0);
  endfunction

  task automatic do_reset(input bit power);
    rst_n = 1'b0;
    if (power) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    if (power) begin
      m_sh[0] = 8'h02; m_sh[1] = 8'h02; m_sh[2] = 8'h0C;
      m_lk = 1'b0; m_wr = 1'b0;
    end
    chk(cfg_state == 3'd5, "R1 load state", cfg_state, 5);
    chk(out_en == 1'b0, "R1 out_en in load", out_en, 0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) m_w[i] = m_sh[i];
    m_st = 0;
    chk(cfg_state == 3'd0, "R1 idle after load", cfg_state, 0);
    chk_words(power ? "R1 default words" : "R11 reload from shadow");
    chk(nv_locked == m_lk, "R1 lock flag", nv_locked, m_lk);
    chk(nv_written == m_wr, "R1 written flag", nv_written, m_wr);
  endtask

  // send a ten-bit frame, update the model, compare
  task automatic frame(input logic c0, input logic c1, input logic [7:0] p, input string tag);
    bit exp_prog = 0, exp_lock = 0;
    send_bits({p, c1, c0}, 10);
    if (m_st == 1) begin
      if (!(c0 && c1)) m_w[word_index(c0, c1)] = p;
      else if (p == 8'h0F || p == 8'hAA) begin
        m_st = (p == 8'hAA) ? 3 : 2;
        if (!m_lk) begin
          for (int i = 0; i < 3; i++) m_sh[i] = m_w[i];
          m_wr = 1'b1;
          exp_prog = 1;
          if (p == 8'hAA) begin m_lk = 1'b1; exp_lock = 1; end
        end
      end else m_st = 0;
    end else if (m_st == 2 || m_st == 3) begin
      if (c0 && c1 && p == 8'h00) m_st = 0;
    end
    chk(cfg_state == m_st[2:0], tag, cfg_state, m_st);
    chk_words(tag);
    chk(prog_strobe == exp_prog, tag, prog_strobe, exp_prog);
    chk(lock_strobe == exp_lock, tag, lock_strobe, exp_lock);
    chk(nv_locked == m_lk, tag, nv_locked, m_lk);
    chk(nv_written == m_wr, tag, nv_written, m_wr);
  endtask

  task automatic enter_prog();
    send_bits(10'b001100, 6);
    m_st = 1;
    chk(cfg_state == 3'd1, "R2 enter programming", cfg_state, 1);
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    bit_vld = 0; bit_val = 0; timeout = 0; en_pin = 1; rst_n = 0; por_n = 0;
    @(negedge clk);
    do_reset(1);

    // R10: enable pin in idle
    en_pin = 0; #1;
    chk(out_en == 1'b0, "R10 idle en low", out_en, 0);
    en_pin = 1; #1;
    chk(out_en == 1'b1, "R10 idle en high", out_en, 1);

    // R2: foreign group stays idle
    send_bits(10'b101010, 6);
    chk(cfg_state == 3'd0, "R2 unknown code ignored", cfg_state, 0);
    // R3: partial group then timeout
    send_bits(10'b100, 3);
    pulse_timeout();
    chk(cfg_state == 3'd0, "R3 timeout keeps idle", cfg_state, 0);
    enter_prog();
    en_pin = 0; #1;
    chk(out_en == 1'b1, "R10 en ignored in programming", out_en, 1);

    // R4: random word writes, one partial frame flushed by timeout
    for (int k = 0; k < 24; k++) begin
      int s = $urandom_range(0, 2);
      if (k == 5) begin
        send_bits(10'h3FF, 4);
        pulse_timeout();
      end
      frame(s == 1, s == 2, 8'($urandom), "R4 word write");
    end

    // R6: commit without lock, R8: writes in commit state ignored
    frame(1, 1, 8'h0F, "R6 commit plain");
    frame(0, 0, 8'h5A, "R8 write ignored in commit");
    frame(1, 1, 8'h12, "R8 other jump ignored");
    frame(1, 1, 8'h00, "R8 exit commit");

    // R5: exit without commit, R11: reload on rst_n
    enter_prog();
    frame(1, 0, 8'hC3, "R4 uncommitted write");
    frame(1, 1, 8'hFF, "R5 exit jump");
    do_reset(0);
    enter_prog();
    frame(1, 1, 8'h33, "R5 undefined jump");

    // R6 with lock, R7 refusal afterwards
    enter_prog();
    frame(0, 1, 8'h81, "R4 word2 write");
    frame(1, 1, 8'hAA, "R6 commit with lock");
    frame(1, 1, 8'h00, "R8 exit locked commit");
    enter_prog();
    frame(0, 0, 8'h7E, "R4 post-lock write");
    frame(1, 1, 8'h0F, "R7 commit refused");
    frame(1, 1, 8'h00, "R8 exit");
    enter_prog();
    frame(1, 1, 8'hAA, "R7 locked commit refused");
    frame(1, 1, 8'h00, "R8 exit");
    do_reset(0);

    // R9: read-back length
    en_pin = 1;
    send_bits(10'b110111, 6);
    chk(cfg_state == 3'd4, "R2 enter read-back", cfg_state, 4);
    en_pin = 0; #1;
    chk(out_en == 1'b1, "R10 en ignored in read-back", out_en, 1);
    for (int i = 0; i < 29; i++) send_bit(1'($urandom));
    chk(cfg_state == 3'd4, "R9 still read-back after 29", cfg_state, 4);
    send_bit(1'b0);
    chk(cfg_state == 3'd0, "R9 idle after 30", cfg_state, 0);
    chk_words("R9 words kept");
    // R3: timeout ends read-back
    send_bits(10'b110111, 6);
    send_bits(10'h0, 5);
    pulse_timeout();
    chk(cfg_state == 3'd0, "R3 timeout ends read-back", cfg_state, 0);
    chk(out_en == 1'b0, "R10 idle follows pin", out_en, 0);

    // R1: power-on restores defaults
    do_reset(1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule